// File: doc/BRIEF.md
# Sampler Acquisition Control Registers

This block is the control register file for a 16-channel logic sampler. Software reaches it through a plain byte-wide register port (address, write data, write strobe and a combinational read path). It holds shadow copies of a channel-enable mask, a divide-minus-one value and a base-clock select. A fixed three-write handshake on the control register copies the shadows into working registers. Once that handshake has run, the sampler can be started and stopped.

While running, the block produces a one-cycle sample strobe every (divider+1) cycles of the selected base clock. The base clock is generated outside the block; the block only reports which of the two base clocks (100 MHz or 160 MHz) the latched configuration asks for. When the configuration is latched, the block checks the resulting sample rate against a limit that tightens as more channels are enabled. An illegal configuration raises an error flag, and a start command is then refused.

Top module: `smp_acq_regs`

## Requirements
- R1: After reset, the control register (address 1) reads 0x08, the divider, mask and clock-select registers read 0x00, and `running`, `sample_stb`, `cfg_err` and `clk_sel` are low.
- R2: Addresses 2 (mask bits 7..0), 3 (mask bits 15..8), 4 (divide-minus-one) and 10 (clock select, bit 0 used) read back the byte last written to them.
- R3: Reads of any address other than 1, 2, 3, 4 and 10 return 0x00, and writes to those addresses change no register and no output.
- R4: Starting from idle, writing 0x40, then 0x42, then 0x40 to address 1 leaves the block configured. The control register reads 0x08 after the first and second writes and 0x48 after the third.
- R5: Only the 0x42 step of the handshake copies the shadow divider, clock select and mask into the working registers. Shadow writes made after that step have no effect on the strobe period, `clk_sel` or `chan_en` until the next handshake.
- R6: Writing 0x41 to address 1 while configured, with `cfg_err` low, sets `running` on the next cycle. The control register then reads 0x49.
- R7: While running, `sample_stb` is high for exactly one cycle in every (div+1) cycles, where div is the latched divide-minus-one value. The first strobe falls div+1 cycles after the start write is taken. The strobe is never high when `running` is low.
- R8: Writing 0x00 to address 1 returns the block to idle from any state. On the next cycle `running` and `sample_stb` are low and the control register reads 0x08.
- R9: At the latch step, `cfg_err` is set when the rate exceeds the limit for the number of enabled channels, and cleared otherwise. The rate is base/(div+1) MHz, with base 100 for select 0 and 160 for select 1. The limit is 100 MHz for 0 to 3 channels, 50 for 4 to 6, 40 for 7, 32 for 8 or 9, 25 for 10 to 12 and 16 for 13 or more. A rate equal to the limit is legal.
- R10: A start write (0x41) made while `cfg_err` is high is ignored: `running` stays low and the control register keeps reading 0x48.
- R11: `clk_sel` equals bit 0 of the clock-select byte as latched at the last handshake, and `chan_en` equals the latched mask.
- R12: Control writes that are out of sequence are ignored. A 0x42 write outside the armed step and a 0x41 write outside the configured state change nothing, so an out-of-order handshake never reaches 0x48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one byte per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sample_stb | output | 1 | One-cycle sample enable strobe |
| running | output | 1 | High while acquisition runs |
| cfg_err | output | 1 | Latched configuration breaks the rate limit |
| clk_sel | output | 1 | Latched base-clock select (0: 100 MHz, 1: 160 MHz) |
| chan_en | output | 16 | Latched channel-enable mask |

## Verification
The bench builds the block with its default parameters: 16 channels, an 8-bit divider, and base clocks of 100 MHz and 160 MHz. With these values, every limit tier and both base clocks are within reach in a few dozen register writes. The bench drives configurations that land exactly on a limit (8 channels at 160/5 MHz and 3 channels at 100 MHz), one cycle past a limit (13 channels at divide 6), and the over-limit case of the 160 MHz clock left undivided. The divide-by-one case lets the strobe run on every cycle.

// File: rtl/smp_acq_pkg.sv
package smp_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LATCHED,
    ST_CONFIG,
    ST_RUN
  } acq_state_e;

  // Register addresses decoded by the host software
  localparam int A_CTRL    = 1;
  localparam int A_MASK_LO = 2;
  localparam int A_DIV     = 4;
  localparam int A_CLKSEL  = 10;

  // Control commands
  localparam logic [7:0] CMD_STOP  = 8'h00;
  localparam logic [7:0] CMD_ARM   = 8'h40;
  localparam logic [7:0] CMD_GO    = 8'h41;
  localparam logic [7:0] CMD_LATCH = 8'h42;

  // Status readback bits
  localparam logic [7:0] STS_READY = 8'h08;
  localparam logic [7:0] STS_CFG   = 8'h40;
  localparam logic [7:0] STS_RUN   = 8'h01;

  // Highest legal sample rate in MHz for a given number of enabled channels
  function automatic int unsigned chan_limit_mhz(input int unsigned n);
    if (n >= 13)      return 16;
    else if (n >= 10) return 25;
    else if (n >= 8)  return 32;
    else if (n >= 7)  return 40;
    else if (n >= 4)  return 50;
    else              return 100;
  endfunction

  // base/(div+1) > limit, rewritten without division
  function automatic logic rate_illegal(input logic sel, input int unsigned div_m1,
                                        input int unsigned nchan,
                                        input int unsigned base0, input int unsigned base1);
    int unsigned base;
    base = sel ? base1 : base0;
    return base > chan_limit_mhz(nchan) * (div_m1 + 1);
  endfunction

endpackage

// File: rtl/smp_acq_shadow.sv
module smp_acq_shadow
  import smp_acq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHANNELS = 16,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [CHANNELS-1:0] sh_mask,
  output logic [DIV_W-1:0]    sh_div,
  output logic [7:0]          sh_sel
);
  localparam int MASK_BYTES = CHANNELS / 8;

  for (genvar g = 0; g < MASK_BYTES; g++) begin : g_mask_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        sh_mask[g*8 +: 8] <= '0;
      else if (we && addr == ADDR_W'(A_MASK_LO + g))
        sh_mask[g*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_div <= '0;
      sh_sel <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(A_DIV))    sh_div <= wdata[DIV_W-1:0];
      if (addr == ADDR_W'(A_CLKSEL)) sh_sel <= wdata;
    end
  end

endmodule

// File: rtl/smp_acq_fsm.sv
module smp_acq_fsm
  import smp_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] cmd,
  input  logic       shadow_illegal,
  output acq_state_e state,
  output logic       latch_evt,
  output logic       start_acc,
  output logic       cfg_err
);
  acq_state_e nxt;

  assign latch_evt = ctrl_wr && cmd == CMD_LATCH && state == ST_ARMED;
  assign start_acc = ctrl_wr && cmd == CMD_GO && state == ST_CONFIG && !cfg_err;

  always_comb begin
    nxt = state;
    if (ctrl_wr) begin
      unique case (cmd)
        CMD_STOP:  nxt = ST_IDLE;
        CMD_ARM: begin
          if (state == ST_IDLE)         nxt = ST_ARMED;
          else if (state == ST_LATCHED) nxt = ST_CONFIG;
        end
        CMD_LATCH: if (latch_evt) nxt = ST_LATCHED;
        CMD_GO:    if (start_acc) nxt = ST_RUN;
        default:   nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cfg_err <= 1'b0;
    end else begin
      state <= nxt;
      if (latch_evt) cfg_err <= shadow_illegal;
    end
  end

endmodule

// File: rtl/smp_acq_divider.sv
module smp_acq_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_m1,
  output logic             stb
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = cnt == div_m1;
  assign stb  = run && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (wrap)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/smp_acq_regs.sv
module smp_acq_regs
  import smp_acq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CHANNELS  = 16,
  parameter int DIV_W     = 8,
  parameter int BASE0_MHZ = 100,
  parameter int BASE1_MHZ = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [7:0]          reg_wdata,
  input  logic                reg_we,
  output logic [7:0]          reg_rdata,
  output logic                sample_stb,
  output logic                running,
  output logic                cfg_err,
  output logic                clk_sel,
  output logic [CHANNELS-1:0] chan_en
);
  localparam int MASK_BYTES = CHANNELS / 8;

  logic [CHANNELS-1:0] sh_mask;
  logic [DIV_W-1:0]    sh_div;
  logic [7:0]          sh_sel;
  logic [DIV_W-1:0]    div_q;
  logic                ctrl_wr;
  logic                shadow_illegal;
  logic                latch_evt;
  logic                start_acc;
  acq_state_e          state;
  logic [7:0]          status;

  assign ctrl_wr = reg_we && reg_addr == ADDR_W'(A_CTRL);
  assign shadow_illegal = rate_illegal(sh_sel[0], int'(sh_div), int'($countones(sh_mask)),
                                       BASE0_MHZ, BASE1_MHZ);

  smp_acq_shadow #(.ADDR_W(ADDR_W), .CHANNELS(CHANNELS), .DIV_W(DIV_W)) i_shadow (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sh_mask(sh_mask), .sh_div(sh_div), .sh_sel(sh_sel)
  );

  smp_acq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cmd(reg_wdata),
    .shadow_illegal(shadow_illegal), .state(state), .latch_evt(latch_evt),
    .start_acc(start_acc), .cfg_err(cfg_err)
  );

  // Working copy taken at the latch step only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      clk_sel <= 1'b0;
      chan_en <= '0;
    end else if (latch_evt) begin
      div_q   <= sh_div;
      clk_sel <= sh_sel[0];
      chan_en <= sh_mask;
    end
  end

  assign running = state == ST_RUN;

  smp_acq_divider #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(start_acc),
    .div_m1(div_q), .stb(sample_stb)
  );

  always_comb begin
    status = STS_READY;
    if (state == ST_CONFIG || state == ST_RUN) status = status | STS_CFG;
    if (state == ST_RUN) status = status | STS_RUN;
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_W'(A_CTRL))   reg_rdata = status;
    if (reg_addr == ADDR_W'(A_DIV))    reg_rdata = 8'(sh_div);
    if (reg_addr == ADDR_W'(A_CLKSEL)) reg_rdata = sh_sel;
    for (int b = 0; b < MASK_BYTES; b++)
      if (reg_addr == ADDR_W'(A_MASK_LO + b)) reg_rdata = sh_mask[b*8 +: 8];
  end

endmodule

// File: rtl/smp_acq_chk.sv
module smp_acq_chk #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              running,
  input logic              sample_stb,
  input logic              cfg_err,
  input logic              clk_sel,
  input logic              latch_evt,
  input logic              start_acc,
  input logic [DIV_W-1:0]  div_q
);
  logic mapped;
  assign mapped = reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2) || reg_addr == ADDR_W'(3)
               || reg_addr == ADDR_W'(4) || reg_addr == ADDR_W'(10);

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 8'h00);

  p_stb_only_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> running);

  p_first_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && div_q == '0 |=> sample_stb);

  p_stb_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb && div_q != '0 |=> !sample_stb);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == ADDR_W'(1) && reg_wdata == 8'h00 |=> !running && !sample_stb);

  p_start_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running && cfg_err && reg_we && reg_addr == ADDR_W'(1) && reg_wdata == 8'h41 |=> !running);

  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(clk_sel));

endmodule

bind smp_acq_regs smp_acq_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .running(running), .sample_stb(sample_stb), .cfg_err(cfg_err),
  .clk_sel(clk_sel), .latch_evt(latch_evt), .start_acc(start_acc), .div_q(div_q)
);

// File: tb/test_smp_acq_regs.sv
module test_smp_acq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic        stb, run, err, sel;
  logic [15:0] chan;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smp_acq_regs i_smp_acq_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata), .sample_stb(stb), .running(run), .cfg_err(err),
    .clk_sel(sel), .chan_en(chan)
  );

  // ---------------- behavioural reference ----------------
  // step: 0 idle, 1 armed, 2 latched, 3 configured, 4 running
  int          m_step;
  int          m_phase;
  bit          m_err, m_sel;
  int          m_div;
  logic [7:0]  s_lo, s_hi, s_div, s_sel;
  logic [15:0] m_chan;

  function automatic bit over_limit(int base, int divm1, logic [15:0] mask);
    int  n = 0;
    real rate, lim;
    for (int i = 0; i < 16; i++) if (mask[i]) n++;
    rate = real'(base) / real'(divm1 + 1);
    lim = 100.0;
    if (n >= 4)  lim = 50.0;
    if (n >= 7)  lim = 40.0;
    if (n >= 8)  lim = 32.0;
    if (n >= 10) lim = 25.0;
    if (n >= 13) lim = 16.0;
    return rate > lim;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_phase = 0; m_err = 0; m_sel = 0; m_div = 0; m_chan = 0;
      s_lo = 0; s_hi = 0; s_div = 0; s_sel = 0;
    end else begin
      int next_step = m_step;
      if (m_step == 4) m_phase = (m_phase == m_div) ? 0 : m_phase + 1;
      if (we) begin
        case (addr)
          4'd2: s_lo = wdata;
          4'd3: s_hi = wdata;
          4'd4: s_div = wdata;
          4'd10: s_sel = wdata;
          4'd1: begin
            if (wdata == 8'h00) next_step = 0;
            else if (wdata == 8'h40 && m_step == 0) next_step = 1;
            else if (wdata == 8'h40 && m_step == 2) next_step = 3;
            else if (wdata == 8'h42 && m_step == 1) begin
              next_step = 2;
              m_div = s_div; m_sel = s_sel[0]; m_chan = {s_hi, s_lo};
              m_err = over_limit(s_sel[0] ? 160 : 100, s_div, {s_hi, s_lo});
            end else if (wdata == 8'h41 && m_step == 3 && !m_err) begin
              next_step = 4; m_phase = 0;
            end
          end
          default: ;
        endcase
      end
      if (next_step != 4) m_phase = 0;
      m_step = next_step;
    end
  end

  function automatic logic [7:0] exp_read(logic [3:0] a);
    case (a)
      4'd1: return (m_step == 4) ? 8'h49 : (m_step == 3) ? 8'h48 : 8'h08;
      4'd2: return s_lo;
      4'd3: return s_hi;
      4'd4: return s_div;
      4'd10: return s_sel;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(run == (m_step == 4), "R6/R8 running", run, m_step == 4);
      chk(stb == (m_step == 4 && m_phase == m_div), "R7 sample_stb", stb,
          m_step == 4 && m_phase == m_div);
      chk(err == m_err, "R9 cfg_err", err, m_err);
      chk(sel == m_sel && chan == m_chan, "R11 clk_sel/chan_en", {sel, chan}, {m_sel, m_chan});
      chk(rdata == exp_read(addr), "R2 readback", rdata, exp_read(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd_is(input logic [3:0] a, input logic [7:0] expv, input string req);
    @(posedge clk); #1; addr = a;
    @(negedge clk);
    chk(rdata == expv, req, rdata, expv);
  endtask

  task automatic setup(input logic [7:0] s, input logic [7:0] d, input logic [15:0] m);
    wr(4'd1, 8'h00);
    wr(4'd2, m[7:0]); wr(4'd3, m[15:8]); wr(4'd4, d); wr(4'd10, s);
    wr(4'd1, 8'h40); wr(4'd1, 8'h42); wr(4'd1, 8'h40);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); #1 rst_n = 1'b1;
    // R1 reset state
    rd_is(4'd1, 8'h08, "R1 ctrl after reset");
    rd_is(4'd4, 8'h00, "R1 div after reset");
    chk(!run && !stb && !err && !sel, "R1 outputs after reset", {run, stb, err, sel}, 0);

    // R2 shadow readback, R3 unmapped
    wr(4'd2, 8'h03); wr(4'd3, 8'h00); wr(4'd4, 8'h03); wr(4'd10, 8'h00);
    rd_is(4'd2, 8'h03, "R2 mask lo");
    rd_is(4'd4, 8'h03, "R2 div");
    wr(4'd5, 8'hAA); wr(4'd0, 8'h55); wr(4'd15, 8'hFF);
    rd_is(4'd5, 8'h00, "R3 unmapped 5");
    rd_is(4'd15, 8'h00, "R3 unmapped 15");
    rd_is(4'd4, 8'h03, "R3 div untouched");

    // R4 handshake
    wr(4'd1, 8'h40); rd_is(4'd1, 8'h08, "R4 after arm");
    wr(4'd1, 8'h42); rd_is(4'd1, 8'h08, "R4 after latch");
    wr(4'd1, 8'h40); rd_is(4'd1, 8'h48, "R4 configured");

    // R5 later shadow write has no effect, R6 start, R7 period 4
    wr(4'd4, 8'h00); wr(4'd10, 8'h01);
    chk(sel == 1'b0, "R5 clk_sel unchanged", sel, 0);
    wr(4'd1, 8'h41);
    rd_is(4'd1, 8'h49, "R6 running");
    idle(20);
    wr(4'd1, 8'h00);
    rd_is(4'd1, 8'h08, "R8 stopped");
    idle(4);

    // R9/R10/R11: 160 MHz undivided breaks the overall limit
    setup(8'h01, 8'h00, 16'h0003);
    chk(err == 1'b1, "R9 160MHz undivided", err, 1);
    chk(sel == 1'b1, "R11 clk_sel latched", sel, 1);
    wr(4'd1, 8'h41);
    rd_is(4'd1, 8'h48, "R10 start refused");
    chk(!run, "R10 not running", run, 0);

    // R9 tiers
    setup(8'h00, 8'h05, 16'h1FFF);
    chk(err == 1'b1, "R9 13ch at 16.7MHz", err, 1);
    setup(8'h00, 8'h06, 16'h1FFF);
    chk(err == 1'b0, "R9 13ch at 14.3MHz", err, 0);
    setup(8'h01, 8'h04, 16'h00FF);
    chk(err == 1'b0, "R9 8ch at exactly 32MHz", err, 0);
    setup(8'h01, 8'h03, 16'h00FF);
    chk(err == 1'b1, "R9 8ch at 40MHz", err, 1);
    setup(8'h00, 8'h01, 16'h007F);
    chk(err == 1'b1, "R9 7ch at 50MHz", err, 1);

    // R7 undivided strobe every cycle, 3 channels at exactly 100 MHz
    setup(8'h00, 8'h00, 16'h0007);
    chk(err == 1'b0, "R9 3ch at 100MHz", err, 0);
    wr(4'd1, 8'h41);
    @(negedge clk);
    chk(stb == 1'b1, "R7 undivided strobe", stb, 1);
    idle(10);

    // R7 long period with restart
    setup(8'h01, 8'h09, 16'h0001);
    wr(4'd1, 8'h41);
    idle(35);

    // R12 out-of-order handshake
    wr(4'd1, 8'h00);
    wr(4'd1, 8'h42); wr(4'd1, 8'h40);
    rd_is(4'd1, 8'h08, "R12 latch before arm ignored");
    wr(4'd1, 8'h40);
    rd_is(4'd1, 8'h08, "R12 never configured");
    wr(4'd1, 8'h41);
    chk(!run, "R12 start outside configured", run, 0);
    idle(3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule